// File: doc/BRIEF.md
# Fine-Scroll Display Address Generator

This block generates the screen-memory byte addresses that feed a character-oriented bitmap display. In this memory layout, eight consecutive bytes make up one column of an eight-line character cell, and a character row is a run of such cells. Software writes a display start address through a small byte-wide register port. The start address has 2-byte resolution, so the first visible scanline can fall on any even line inside a cell.

The block follows the sub-cell offset line by line. As a result, the frame opens with a partial character row and closes with the rest of that row's lines. The timing generator supplies three strobes:

- a frame strobe, which starts visible line 0;
- a line strobe, which starts each later line;
- a byte strobe, which marks each fetch slot within a line.

For each accepted slot, the block returns a fetch request together with the address to fetch. Addresses that run past the top of the address space wrap back to a fixed screen base.

Two controls hide parts of the picture. A programmable count of bottom lines can be blanked. A suspend control stops every fetch and holds the blank output high. Both are sampled at each line boundary. The start address and the granularity mode are taken only at the frame strobe.

Top module: `fine_scroll_agen`

## Requirements
- R1: After reset, `blank` is 1 and `fetch_req` is 0. Byte strobes that arrive before the first frame strobe produce no fetch.
- R2: Register select 0 holds start bits [ADDR_W-1:8] in its low bits. Select 1 holds start bits [7:1] in its bits [7:1]. Start bit 0 is always 0, and written bit 0 is ignored. With no offset and fine mode, the first fetch of a frame (line 0, slot 0) is the start address itself.
- R3: When bit 1 of the control register (select 3) is 1 at the frame strobe, the low 6 bits of the latched start address are forced to 0.
- R4: Writes to the start registers during a frame do not change that frame's addresses. They apply from the next frame strobe.
- R5: Let S be the latched start and t = S[2:0] + n. The address for visible line n, slot c is (S with bits [2:0] cleared) + (t / 8) * ROW_BYTES + 8*c + (t mod 8), where ROW_BYTES = 8*COLS.
- R6: Whenever the row base or a fetch address reaches 2^ADDR_W or more, it is reduced by (2^ADDR_W - SCREEN_BASE).
- R7: Only the first COLS byte strobes of a line produce fetches. Further strobes in that line are ignored.
- R8: Lines with index LINES_VIS or higher have `blank` = 1 and no fetches.
- R9: A line n with n + BL >= LINES_VIS is blanked and not fetched. BL is the blank-lines register (select 2), sampled at the line's strobe.
- R10: If control bit 0 (suspend) is 1 at a line strobe, that line has `blank` = 1 and no fetches.
- R11: `fetch_req` is a one-cycle pulse in the cycle after an accepted byte strobe, with `fetch_addr` valid in the same cycle. `blank` changes only in the cycle after a frame or line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 start high, 1 start low, 2 blank lines, 3 control |
| reg_wdata | input | 8 | Register write data |
| frame_start | input | 1 | Starts visible line 0 and latches the start address |
| line_stb | input | 1 | Starts the next scanline |
| byte_stb | input | 1 | Fetch slot within the current line |
| fetch_req | output | 1 | Fetch request pulse |
| fetch_addr | output | ADDR_W | Screen memory byte address |
| blank | output | 1 | Current line shows blank pixels |

## Verification
The assertions assume the following about the timing generator:

- a byte strobe never shares a cycle with a frame or line strobe;
- register writes are separate from the strobes that sample them.

Under those assumptions, a fetch can only follow a byte strobe inside an active line. The stimulus keeps within these limits by driving every strobe and write as its own single-cycle pulse from sequential tasks. Random start addresses, blank counts and control values are mixed with directed frames that cross the top-of-memory wrap, use coarse mode, suspend mid-frame and rewrite the start address in the middle of a frame.

// File: rtl/fs_agen_pkg.sv
package fs_agen_pkg;

  typedef enum logic [1:0] {
    SEL_START_HI = 2'd0,
    SEL_START_LO = 2'd1,
    SEL_BLANK    = 2'd2,
    SEL_CTRL     = 2'd3
  } fs_sel_e;

  typedef struct packed {
    logic coarse;   // bit 1: 64-byte start granularity
    logic suspend;  // bit 0: stop all fetches, blank display
  } fs_ctrl_t;

endpackage

// File: rtl/fs_regs.sv
module fs_regs
  import fs_agen_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] start_pend,
  output logic [7:0]        blank_lines,
  output fs_ctrl_t          ctrl
);

  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [6:0]      lo_q, lo_d;
  logic [7:0]      bl_q, bl_d;
  fs_ctrl_t        ctrl_q, ctrl_d;

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    bl_d   = bl_q;
    ctrl_d = ctrl_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_START_HI: hi_d = wr_data[HI_W-1:0];
        SEL_START_LO: lo_d = wr_data[7:1];
        SEL_BLANK:    bl_d = wr_data;
        SEL_CTRL:     ctrl_d = fs_ctrl_t'(wr_data[1:0]);
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      bl_q   <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      bl_q   <= bl_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign start_pend  = {hi_q, lo_q, 1'b0};
  assign blank_lines = bl_q;
  assign ctrl        = ctrl_q;

endmodule

// File: rtl/fs_line_seq.sv
module fs_line_seq #(
  parameter int                ADDR_W      = 15,
  parameter int                LINES_VIS   = 256,
  parameter int                LINES_TOTAL = 312,
  parameter int                ROW_BYTES   = 640,
  parameter logic [ADDR_W-1:0] SCREEN_BASE = 15'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_stb,
  input  logic [ADDR_W-1:0] start_pend,
  input  logic              coarse,
  input  logic              suspend,
  input  logic [7:0]        blank_lines,
  output logic              line_active,
  output logic [ADDR_W-1:0] row_base,
  output logic [2:0]        cell_line
);

  localparam int LW = $clog2(LINES_TOTAL + 1);
  localparam logic [LW-1:0]   LT_L   = LW'(LINES_TOTAL);
  localparam logic [15:0]     LV_L   = 16'(LINES_VIS);
  localparam logic [ADDR_W:0] TOP_L  = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W:0] SPAN_L = TOP_L - {1'b0, SCREEN_BASE};
  localparam logic [ADDR_W:0] ROW_L  = (ADDR_W+1)'(ROW_BYTES);

  logic [LW-1:0]     line_q, line_d;
  logic [ADDR_W-1:0] rb_q, rb_d, start_eff;
  logic [2:0]        cl_q, cl_d;
  logic              act_q, act_d;
  logic [ADDR_W:0]   rb_sum;
  logic [15:0]       vis_sum;
  logic              step;

  assign step      = frame_start | line_stb;
  assign start_eff = coarse ? {start_pend[ADDR_W-1:6], 6'b0} : start_pend;
  assign rb_sum    = {1'b0, rb_q} + ROW_L;

  always_comb begin
    line_d = line_q;
    rb_d   = rb_q;
    cl_d   = cl_q;
    if (frame_start) begin
      line_d = '0;
      rb_d   = {start_eff[ADDR_W-1:3], 3'b000};
      cl_d   = start_eff[2:0];
    end else if (line_stb) begin
      if (line_q < LT_L) line_d = line_q + 1'b1;
      cl_d = cl_q + 3'd1;
      if (cl_q == 3'd7) begin
        rb_d = (rb_sum >= TOP_L) ? ADDR_W'(rb_sum - SPAN_L) : rb_sum[ADDR_W-1:0];
      end
    end
    vis_sum = 16'(line_d) + 16'(blank_lines);
    act_d   = (vis_sum < LV_L) && !suspend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= LT_L;
      rb_q   <= '0;
      cl_q   <= '0;
      act_q  <= 1'b0;
    end else if (step) begin
      line_q <= line_d;
      rb_q   <= rb_d;
      cl_q   <= cl_d;
      act_q  <= act_d;
    end
  end

  assign line_active = act_q;
  assign row_base    = rb_q;
  assign cell_line   = cl_q;

endmodule

// File: rtl/fs_fetch_gen.sv
module fs_fetch_gen #(
  parameter int                ADDR_W      = 15,
  parameter int                COLS        = 80,
  parameter logic [ADDR_W-1:0] SCREEN_BASE = 15'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_stb,
  input  logic              byte_stb,
  input  logic              line_active,
  input  logic [ADDR_W-1:0] row_base,
  input  logic [2:0]        cell_line,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr
);

  localparam int CW = $clog2(COLS + 1);
  localparam logic [CW-1:0]   COLS_L = CW'(COLS);
  localparam logic [ADDR_W:0] TOP_L  = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [ADDR_W:0] SPAN_L = TOP_L - {1'b0, SCREEN_BASE};

  logic [CW-1:0]     col_q, col_d;
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W:0]   sum;
  logic              take;

  assign take = byte_stb && line_active && (col_q < COLS_L);
  assign sum  = {1'b0, row_base} + (ADDR_W+1)'({col_q, 3'b000})
              + (ADDR_W+1)'(cell_line);

  always_comb begin
    col_d  = col_q;
    req_d  = 1'b0;
    addr_d = addr_q;
    if (frame_start || line_stb) begin
      col_d = '0;
    end else if (take) begin
      col_d  = col_q + 1'b1;
      req_d  = 1'b1;
      addr_d = (sum >= TOP_L) ? ADDR_W'(sum - SPAN_L) : sum[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      col_q  <= col_d;
      req_q  <= req_d;
      addr_q <= addr_d;
    end
  end

  assign fetch_req  = req_q;
  assign fetch_addr = addr_q;

endmodule

// File: rtl/fine_scroll_agen.sv
module fine_scroll_agen
  import fs_agen_pkg::*;
#(
  parameter int                ADDR_W      = 15,
  parameter int                LINES_VIS   = 256,
  parameter int                LINES_TOTAL = 312,
  parameter int                COLS        = 80,
  parameter logic [ADDR_W-1:0] SCREEN_BASE = 15'h3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic              frame_start,
  input  logic              line_stb,
  input  logic              byte_stb,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              blank
);

  localparam int ROW_BYTES = COLS * 8;

  logic [ADDR_W-1:0] start_pend;
  logic [7:0]        blank_lines;
  fs_ctrl_t          ctrl;
  logic              line_active;
  logic [ADDR_W-1:0] row_base;
  logic [2:0]        cell_line;

  fs_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .start_pend(start_pend),
    .blank_lines(blank_lines), .ctrl(ctrl)
  );

  fs_line_seq #(
    .ADDR_W(ADDR_W), .LINES_VIS(LINES_VIS), .LINES_TOTAL(LINES_TOTAL),
    .ROW_BYTES(ROW_BYTES), .SCREEN_BASE(SCREEN_BASE)
  ) u_line (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_stb(line_stb),
    .start_pend(start_pend), .coarse(ctrl.coarse), .suspend(ctrl.suspend),
    .blank_lines(blank_lines), .line_active(line_active),
    .row_base(row_base), .cell_line(cell_line)
  );

  fs_fetch_gen #(
    .ADDR_W(ADDR_W), .COLS(COLS), .SCREEN_BASE(SCREEN_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_stb(line_stb),
    .byte_stb(byte_stb), .line_active(line_active), .row_base(row_base),
    .cell_line(cell_line), .fetch_req(fetch_req), .fetch_addr(fetch_addr)
  );

  assign blank = !line_active;

endmodule

// File: rtl/fs_agen_chk.sv
module fs_agen_chk #(
  parameter int COLS = 80
) (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic line_stb,
  input logic byte_stb,
  input logic suspend_cfg,
  input logic fetch_req,
  input logic blank
);

  int unsigned line_fetches;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_fetches <= 0;
    else if (frame_start || line_stb) line_fetches <= 0;
    else if (fetch_req) line_fetches <= line_fetches + 1;
  end

  // R9 R10
  fetch_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !blank);

  // R11
  fetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ($past(byte_stb) && !$past(frame_start) && !$past(line_stb)));

  // R10
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(frame_start) || $past(line_stb)) && $past(suspend_cfg)) |-> blank);

  // R11
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_start) && !$past(line_stb)) |-> $stable(blank));

  // R7
  fetch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_fetches <= COLS);

endmodule

bind fine_scroll_agen fs_agen_chk #(.COLS(COLS)) u_fs_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_stb(line_stb),
  .byte_stb(byte_stb), .suspend_cfg(ctrl.suspend), .fetch_req(fetch_req),
  .blank(blank)
);

// File: tb/test_fine_scroll_agen.sv
module test_fine_scroll_agen;

  localparam int AW   = 15;
  localparam int LV   = 32;
  localparam int LT   = 40;
  localparam int NC   = 8;
  localparam int ROWB = NC * 8;
  localparam int BASE = 'h7000;
  localparam int TOP  = 1 << AW;
  localparam int SPAN = TOP - BASE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_sel = '0;
  logic [7:0]    reg_wdata = '0;
  logic          frame_start = 1'b0;
  logic          line_stb = 1'b0;
  logic          byte_stb = 1'b0;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          blank;

  fine_scroll_agen #(
    .ADDR_W(AW), .LINES_VIS(LV), .LINES_TOTAL(LT), .COLS(NC),
    .SCREEN_BASE(15'h7000)
  ) i_fine_scroll_agen (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .line_stb(line_stb),
    .byte_stb(byte_stb), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .blank(blank)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model shadows
  int m_hi = 0, m_lo = 0, m_bl = 0, m_susp = 0, m_coarse = 0;
  int f_s = 0;
  bit last_wrap;
  string frame_tag = "R5";

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(int sel, int data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel[1:0]; reg_wdata = data[7:0];
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (sel)
      0: m_hi = data & 8'h7f;
      1: m_lo = data & 8'hfe;
      2: m_bl = data & 8'hff;
      default: begin m_susp = data & 1; m_coarse = (data >> 1) & 1; end
    endcase
  endtask

  task automatic set_start(int s);
    write_reg(0, (s >> 8) & 8'hff);
    write_reg(1, (s & 8'hff) | ($urandom % 2));  // bit 0 ignored (R2)
  endtask

  function automatic int exp_addr(int n, int c);
    int rb, lic, a;
    rb = f_s & ~7;
    lic = f_s & 7;
    last_wrap = 0;
    for (int i = 0; i < n; i++) begin
      if (lic == 7) begin
        lic = 0;
        rb = rb + ROWB;
        if (rb >= TOP) begin rb = rb - SPAN; last_wrap = 1; end
      end else lic++;
    end
    a = rb + c * 8 + lic;
    if (a >= TOP) begin a = a - SPAN; last_wrap = 1; end
    return a;
  endfunction

  task automatic do_line(int n, int wr_line, int wr_sel, int wr_data);
    bit act;
    int k;
    string tag;
    @(negedge clk);
    if (n == 0) begin
      frame_start = 1'b1;
      f_s = (m_hi << 8) | m_lo;
      if (m_coarse != 0) f_s = f_s & ~63;
    end else line_stb = 1'b1;
    act = ((n + m_bl) < LV) && (m_susp == 0);
    @(negedge clk);
    frame_start = 1'b0; line_stb = 1'b0;
    if (m_susp != 0 && n < LV) tag = "R10";
    else if (n >= LV) tag = "R8";
    else if (!act) tag = "R9";
    else tag = "R11";
    chk(tag, int'(blank), int'(!act));
    k = NC - 1 + ($urandom % 4);
    for (int c = 0; c < k; c++) begin
      repeat ($urandom % 2) @(negedge clk);
      byte_stb = 1'b1;
      @(negedge clk);
      byte_stb = 1'b0;
      if (c >= NC) chk("R7", int'(fetch_req), 0);
      else if (!act) chk(tag, int'(fetch_req), 0);
      else begin
        int e;
        string at;
        chk("R11", int'(fetch_req), 1);
        e = exp_addr(n, c);
        if (last_wrap) at = "R6";
        else if (n == 0 && c == 0 && m_coarse == 0) at = "R2";
        else at = frame_tag;
        chk(at, int'(fetch_addr), e);
      end
    end
    @(negedge clk);
    chk("R11", int'(fetch_req), 0);
    if (n == wr_line) write_reg(wr_sel, wr_data);
  endtask

  task automatic run_frame(int wr_line, int wr_sel, int wr_data);
    for (int n = 0; n < LT; n++) do_line(n, wr_line, wr_sel, wr_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(blank), 1);
    chk("R1", int'(fetch_req), 0);
    byte_stb = 1'b1; @(negedge clk); byte_stb = 1'b0;
    chk("R1", int'(fetch_req), 0);

    // offset of 2 lines into a cell: 6-line first row, 2-line last row
    set_start('h7002);
    frame_tag = "R5";
    run_frame(-1, 0, 0);

    // wrap past top of memory, bottom 6 lines blanked
    set_start('h7FC4);
    write_reg(2, 6);
    run_frame(-1, 0, 0);

    // coarse granularity
    set_start('h7ABE);
    write_reg(3, 2);
    frame_tag = "R3";
    run_frame(-1, 0, 0);

    // suspend, released mid-frame
    write_reg(3, 1);
    write_reg(2, 0);
    frame_tag = "R5";
    run_frame(5, 3, 0);

    // start rewritten mid-frame: current frame keeps old start
    frame_tag = "R4";
    run_frame(3, 0, 'h75);
    run_frame(-1, 0, 0);
    frame_tag = "R5";

    for (int f = 0; f < 14; f++) begin
      int s;
      s = (BASE + ($urandom % SPAN)) & ~1;
      set_start(s);
      write_reg(2, ($urandom % 4 == 0) ? ($urandom % 256) : ($urandom % 8));
      write_reg(3, ($urandom % 5 == 0) ? 1 : (($urandom % 3 == 0) ? 2 : 0));
      run_frame($urandom % LT, 2 + ($urandom % 2), $urandom % 8);
      write_reg(3, 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule